// File: doc/BRIEF.md
# Duplex Output Monitor with Triplex Escalation

This block supervises two functional units that compute the same function side by side. After each launch of new inputs it waits a programmable number of cycles for the result to settle, then compares the two output words. A single disagreement is enough to flag trouble. The block then asks for the cold spare unit to be switched in. On the next evaluation it runs a two-out-of-three vote to name the unit that disagrees. It raises a recovery request that carries that verdict and drops back to duplex operation. Each detected fault therefore costs two reconfigurations: one into triplex and one back out.

The monitor also checks its own health. It folds every sampled word from unit A into an XOR accumulator over fixed blocks of 16 samples. At the last sample of a block it compares the running result against a reference word supplied from outside. A mismatch reports a fault in the monitor itself. Recovery requests use a valid/acknowledge handshake. While a request is outstanding, every new detection is masked.

Top module: `dmon_top`

## Requirements
- R1: After reset, triplexMode, recReq, faultIdx and monitorFault are all 0.
- R2: The settle delay is captured from delayCfg on every clock edge at which rstN is low, and a captured value of 0 selects 2. When inValid is seen high at edge t while the monitor is idle, the unit outputs are sampled exactly at edge t+delay and at no other edge.
- R3: inValid pulses that arrive while a sampling delay is still running are ignored and do not restart the delay.
- R4: In duplex mode with no request pending, a sample where feA differs from feB sets triplexMode at that edge. A matching sample leaves it at 0. feC is ignored in duplex mode.
- R5: In triplex mode, the next sample raises recReq and clears triplexMode at the same edge. faultIdx encodes the unit that disagrees: 1 = A, 2 = B, 3 = C, and 0 when all three agree or all three differ.
- R6: recReq stays high, with faultIdx and monitorFault unchanged, until an edge where recAck is high. It is low after that edge.
- R7: While recReq is high, a duplex mismatch does not enter triplex mode and a checksum mismatch raises no request.
- R8: The checksum is the XOR of feA over each block of 16 samples, counted from reset. At the 16th sample, a result that differs from storedSum raises recReq with monitorFault=1 and faultIdx=0, and this takes priority over a duplex mismatch at the same sample. A result equal to storedSum raises nothing. The accumulator then restarts from 0.
- R9: If the triplex evaluation falls on a 16th sample, monitorFault in that request reports the checksum comparison of that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| delayCfg | input | 4 | Settle delay in cycles, captured during reset (0 selects 2) |
| inValid | input | 1 | New inputs were launched into the functional units |
| feA | input | W | Output word of unit A |
| feB | input | W | Output word of unit B |
| feC | input | W | Output word of the standby unit C |
| storedSum | input | W | Reference checksum for one 16-sample block |
| recAck | input | 1 | Acknowledges the recovery request |
| triplexMode | output | 1 | Request for triplex mode; also enables the standby unit |
| recReq | output | 1 | Recovery request (valid) |
| faultIdx | output | 2 | Dissenting unit: 0 none, 1 A, 2 B, 3 C |
| monitorFault | output | 1 | The request reports a checksum fault in the monitor |

## Verification
The sampling instant cannot be seen directly at the ports. The bench holds A and B equal and flips B for a single cycle, so the mismatch lands either exactly on the expected sampling edge or one edge earlier. Only the first case may start an escalation. A repeated launch inside the delay window probes R3. The checksum path needs a 16th sample that falls during a pending request and another that falls in triplex mode. The bench model counts every sample, masked ones included, so it can program storedSum just before the block-closing launch.

// File: rtl/dmon_pkg.sv
package dmon_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic sample;   // capture unit outputs at this edge
    logic triplex;  // the vote result is meaningful
  } dmonStrobe_t;

  // status returned by the datapath
  typedef struct packed {
    logic       pairDiff;
    logic       sumBad;
    logic [1:0] voteIdx;
  } dmonStatus_t;
endpackage

// File: rtl/dmon_datapath.sv
module dmon_datapath
  import dmon_pkg::*;
#(
  parameter int W     = 8,
  parameter int BLOCK = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  dmonStrobe_t stb,
  input  logic [W-1:0] feA,
  input  logic [W-1:0] feB,
  input  logic [W-1:0] feC,
  input  logic [W-1:0] storedSum,
  output dmonStatus_t  status
);
  localparam int CNT_W = $clog2(BLOCK);

  logic [W-1:0]     acc;
  logic [CNT_W-1:0] sampCnt;
  logic             blockEnd;
  logic [1:0]       vote;

  assign blockEnd = (sampCnt == CNT_W'(BLOCK - 1));

  always_comb begin
    if (feA == feB && feB == feC) vote = 2'd0;
    else if (feA == feB)          vote = 2'd3;
    else if (feA == feC)          vote = 2'd2;
    else if (feB == feC)          vote = 2'd1;
    else                          vote = 2'd0;
  end

  always_comb begin
    status.pairDiff = (feA != feB);
    status.sumBad   = blockEnd && ((acc ^ feA) != storedSum);
    status.voteIdx  = stb.triplex ? vote : 2'd0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc     <= '0;
      sampCnt <= '0;
    end else if (stb.sample) begin
      if (blockEnd) begin
        acc     <= '0;
        sampCnt <= '0;
      end else begin
        acc     <= acc ^ feA;
        sampCnt <= sampCnt + 1'b1;
      end
    end
  end

  // R8: the checksum state moves only on a sample strobe
  p_acc_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.sample |=> ($stable(acc) && $stable(sampCnt)));
endmodule

// File: rtl/dmon_ctrl.sv
module dmon_ctrl
  import dmon_pkg::*;
#(
  parameter int DELAY_W   = 4,
  parameter int DEF_DELAY = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DELAY_W-1:0] delayCfg,
  input  logic               inValid,
  input  dmonStatus_t        status,
  input  logic               recAck,
  output dmonStrobe_t        stb,
  output logic               triplexMode,
  output logic               recReq,
  output logic [1:0]         faultIdx,
  output logic               monitorFault
);
  logic [DELAY_W-1:0] delayReg;
  logic [DELAY_W-1:0] cnt;
  logic               busy;

  always_comb begin
    stb.sample  = busy && (cnt == DELAY_W'(1));
    stb.triplex = triplexMode;
  end

  // launch and settle-delay counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      delayReg <= (delayCfg == '0) ? DELAY_W'(DEF_DELAY) : delayCfg;
      busy     <= 1'b0;
      cnt      <= '0;
    end else if (!busy) begin
      if (inValid) begin
        busy <= 1'b1;
        cnt  <= delayReg;
      end
    end else begin
      cnt <= cnt - 1'b1;
      if (cnt == DELAY_W'(1)) busy <= 1'b0;
    end
  end

  // evaluator and actuator
  always_ff @(posedge clk) begin
    if (!rstN) begin
      triplexMode  <= 1'b0;
      recReq       <= 1'b0;
      faultIdx     <= 2'd0;
      monitorFault <= 1'b0;
    end else begin
      if (recReq && recAck) begin
        recReq       <= 1'b0;
        faultIdx     <= 2'd0;
        monitorFault <= 1'b0;
      end
      if (stb.sample && !recReq) begin
        if (triplexMode) begin
          triplexMode  <= 1'b0;
          recReq       <= 1'b1;
          faultIdx     <= status.voteIdx;
          monitorFault <= status.sumBad;
        end else if (status.sumBad) begin
          recReq       <= 1'b1;
          faultIdx     <= 2'd0;
          monitorFault <= 1'b1;
        end else if (status.pairDiff) begin
          triplexMode <= 1'b1;
        end
      end
    end
  end

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (recReq && !recAck) |=> (recReq && $stable(faultIdx) && $stable(monitorFault)));

  p_triplex_exit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (triplexMode && stb.sample) |=> (!triplexMode && recReq));

  p_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    (recReq && !triplexMode) |=> !triplexMode);

  p_mode_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    !stb.sample |=> $stable(triplexMode));
endmodule

// File: rtl/dmon_top.sv
module dmon_top
  import dmon_pkg::*;
#(
  parameter int W         = 8,
  parameter int BLOCK     = 16,
  parameter int DELAY_W   = 4,
  parameter int DEF_DELAY = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DELAY_W-1:0] delayCfg,
  input  logic               inValid,
  input  logic [W-1:0]       feA,
  input  logic [W-1:0]       feB,
  input  logic [W-1:0]       feC,
  input  logic [W-1:0]       storedSum,
  input  logic               recAck,
  output logic               triplexMode,
  output logic               recReq,
  output logic [1:0]         faultIdx,
  output logic               monitorFault
);
  dmonStrobe_t stb;
  dmonStatus_t status;

  dmon_ctrl #(.DELAY_W(DELAY_W), .DEF_DELAY(DEF_DELAY)) i_ctrl (
    .clk(clk), .rstN(rstN), .delayCfg(delayCfg), .inValid(inValid),
    .status(status), .recAck(recAck), .stb(stb),
    .triplexMode(triplexMode), .recReq(recReq),
    .faultIdx(faultIdx), .monitorFault(monitorFault)
  );

  dmon_datapath #(.W(W), .BLOCK(BLOCK)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .feA(feA), .feB(feB), .feC(feC), .storedSum(storedSum),
    .status(status)
  );
endmodule

// File: tb/test_dmon_top.sv
module test_dmon_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [3:0]   delayCfg = 4'd0;
  logic         inValid = 1'b0;
  logic [W-1:0] feA = '0, feB = '0, feC = '0, storedSum = '0;
  logic         recAck = 1'b0;
  logic         triplexMode, recReq, monitorFault;
  logic [1:0]   faultIdx;

  always #2 clk = ~clk;  // 250 MHz

  dmon_top #(.W(W)) i_dmon_top (
    .clk(clk), .rstN(rstN), .delayCfg(delayCfg), .inValid(inValid),
    .feA(feA), .feB(feB), .feC(feC), .storedSum(storedSum), .recAck(recAck),
    .triplexMode(triplexMode), .recReq(recReq), .faultIdx(faultIdx),
    .monitorFault(monitorFault)
  );

  typedef struct { logic [1:0] idx; logic mf; } expItem_t;
  expItem_t expQ[$];

  int checks = 0, errors = 0;
  int dly = 2;
  // independent reference state
  logic         mTriplex = 0, mPending = 0, sumBad = 0;
  logic [W-1:0] mAcc = '0;
  int           mCnt = 0;
  logic         prevReq = 0;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] voteOf(input logic [W-1:0] a, b, c);
    if (a == b && b == c) return 2'd0;
    if (a == b) return 2'd3;
    if (a == c) return 2'd2;
    if (b == c) return 2'd1;
    return 2'd0;
  endfunction

  // set the reference word for a block-closing sample
  task automatic prepSum(input logic [W-1:0] a);
    if (mCnt == 15) storedSum = sumBad ? ~(mAcc ^ a) : (mAcc ^ a);
  endtask

  // reference model of one sampling edge; pushes expected requests
  task automatic model(input logic [W-1:0] a, b, c);
    logic bad;
    expItem_t it;
    bad = (mCnt == 15) && sumBad;
    if (!mPending) begin
      if (mTriplex) begin
        it.idx = voteOf(a, b, c); it.mf = bad;
        expQ.push_back(it); mTriplex = 0; mPending = 1;
      end else if (bad) begin
        it.idx = 2'd0; it.mf = 1'b1;
        expQ.push_back(it); mPending = 1;
      end else if (a != b) mTriplex = 1;
    end
    if (mCnt == 15) begin mCnt = 0; mAcc = '0; end
    else begin mCnt++; mAcc = mAcc ^ a; end
  endtask

  task automatic checkState(input string tag);
    check(triplexMode == mTriplex, {tag, " R4 triplexMode"}, triplexMode, mTriplex);
    check(recReq == mPending, {tag, " R7 recReq"}, recReq, mPending);
  endtask

  // driver: launch one set of inputs and wait past the sampling edge
  task automatic launch(input logic [W-1:0] a, b, c, input string tag);
    @(negedge clk);
    prepSum(a);
    feA = a; feB = b; feC = c; inValid = 1'b1;
    model(a, b, c);
    @(negedge clk); inValid = 1'b0;
    repeat (dly) @(negedge clk);
    checkState(tag);
  endtask

  // B differs only across the edge t+pos; optional second launch at t+1
  task automatic pulse(input logic [W-1:0] a, input int pos, input logic relaunch, input string tag);
    @(negedge clk);
    prepSum(a);
    feA = a; feB = a; feC = a; inValid = 1'b1;
    model(a, (pos == dly) ? ~a : a, a);
    for (int k = 0; k <= dly; k++) begin
      @(negedge clk);
      if (k == 0 && !relaunch) inValid = 1'b0;
      if (k == 1) inValid = 1'b0;
      if (k == pos - 1) feB = ~a;
      if (k == pos) feB = a;
    end
    checkState(tag);
  endtask

  task automatic ack(input string tag);
    repeat (3) @(negedge clk);
    check(recReq == 1'b1, {tag, " R6 held"}, recReq, 1);
    recAck = 1'b1;
    @(negedge clk); recAck = 1'b0;
    check(recReq == 1'b0, {tag, " R6 released"}, recReq, 0);
    mPending = 0;
  endtask

  task automatic doReset(input logic [3:0] cfg);
    @(negedge clk);
    rstN = 1'b0; delayCfg = cfg; recAck = 1'b0; inValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    delayCfg = 4'd9;  // must not matter after reset
    dly = (cfg == 0) ? 2 : int'(cfg);
    mTriplex = 0; mPending = 0; mAcc = '0; mCnt = 0; sumBad = 0;
    expQ.delete();
    check(triplexMode == 0 && recReq == 0 && faultIdx == 0 && monitorFault == 0,
          "R1 reset outputs", {triplexMode, recReq, faultIdx, monitorFault}, 0);
  endtask

  // monitor: every new request is compared with the scoreboard
  always @(negedge clk) begin
    if (!rstN) prevReq <= 1'b0;
    else begin
      if (recReq && !prevReq) begin
        if (expQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL R7 unexpected request actual idx=%0d mf=%0d expected none",
                   faultIdx, monitorFault);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(faultIdx == e.idx, "R5 faultIdx", faultIdx, e.idx);
          check(monitorFault == e.mf, "R8 monitorFault", monitorFault, e.mf);
        end
      end
      prevReq <= recReq;
    end
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    doReset(4'd0);
    for (int i = 0; i < 4; i++) launch(8'(i * 17 + 3), 8'(i * 17 + 3), 8'hEE, "R4 match");
    pulse(8'h21, 1, 1'b0, "R2 early");
    pulse(8'h22, 2, 1'b0, "R2 on edge");
    launch(8'h40, 8'h40, 8'h41, "R5 vote C");
    ack("R6 a");
    pulse(8'h23, 2, 1'b1, "R3 relaunch");
    launch(8'h05, 8'h09, 8'h05, "R5 vote B");
    ack("R6 b");
    launch(8'h01, 8'h02, 8'h03, "R4 mismatch");
    launch(8'h07, 8'h03, 8'h03, "R5 vote A");
    ack("R6 c");
    launch(8'h11, 8'h12, 8'h13, "R4 mismatch");
    launch(8'h66, 8'h66, 8'h66, "R5 vote none");
    ack("R6 d");
    launch(8'h31, 8'h32, 8'h33, "R4 mismatch");
    launch(8'h01, 8'h02, 8'h03, "R5 all differ");
    launch(8'h51, 8'h52, 8'h00, "R7 masked mismatch");
    ack("R6 e");
    // checksum: one good block end, then a bad one
    while (mCnt != 15) launch(8'(mCnt * 7 + 1), 8'(mCnt * 7 + 1), 8'h00, "R8 fill");
    launch(8'h5A, 8'h5A, 8'h00, "R8 sum good");
    sumBad = 1;
    while (mCnt != 15) launch(8'(mCnt * 3 + 9), 8'(mCnt * 3 + 9), 8'h00, "R8 fill");
    launch(8'hA5, 8'hA6, 8'h00, "R8 sum bad priority");
    ack("R6 f");
    // bad block end while a request is pending is masked
    launch(8'h10, 8'h11, 8'h00, "R4 mismatch");
    launch(8'h10, 8'h10, 8'h00, "R5 vote C");
    while (mCnt != 15) launch(8'(mCnt + 40), 8'(mCnt + 40), 8'h00, "R7 fill");
    launch(8'h77, 8'h77, 8'h00, "R7 masked sum");
    ack("R6 g");
    // triplex evaluation on a bad block end carries monitorFault
    while (mCnt != 14) launch(8'(mCnt + 90), 8'(mCnt + 90), 8'h00, "R9 fill");
    launch(8'h0F, 8'h1F, 8'h00, "R9 escalate");
    launch(8'h0F, 8'h0F, 8'h3F, "R9 vote at block end");
    ack("R6 h");
    sumBad = 0;
    // longer delay captured during reset
    doReset(4'd5);
    pulse(8'h44, 4, 1'b0, "R2 early d5");
    pulse(8'h45, 5, 1'b1, "R2 on edge d5");
    launch(8'h45, 8'h46, 8'h45, "R5 vote B d5");
    ack("R6 i");
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R5 scoreboard drained", expQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule